// File: doc/BRIEF.md
# Interrupt Controller Command Sequencer

This block is the programming front end of an eight-input interrupt controller. A host writes bytes to one of two addresses. The block sorts each write into one of four kinds: an initialization restart, a follow-on initialization word, a mode command or an end-of-interrupt/priority command. It holds the resulting configuration, which is the vector base, single or cascaded operation, automatic end-of-interrupt, fully nested operation, read selection, special masking, poll arming and rotation on automatic end-of-interrupt. It also holds the eight-bit interrupt mask.

Commands that act on the in-service and priority state leave the block as one-cycle strobes, paired with a three-bit line number where the command names a line. The pending and in-service registers and the priority resolver sit outside the block. Their contents come back on input ports, so the block can return them on a read. When a poll is armed, the next read returns the resolver's current winner, and the block tells the resolver to acknowledge that line.

Top module: `irq_cmd_sequencer`

## Requirements
- R1: After reset every configuration output, the mask and every strobe are 0, and `init_busy` is 0.
- R2: A write at address 0 with bit 4 set pulses `restart_stb` for one cycle. It clears the mask, the vector base and every mode flag, including poll. It takes `single_mode` from bit 1 and `fourth_req` from bit 0, and it raises `init_busy` at the base-word step.
- R3: In the base-word step, an address-1 write sets `vec_base` to the data with bits 2:0 cleared. The next step depends on the mode. Single mode with a fourth word goes to the fourth-word step. Single mode without one goes to idle. Cascaded mode goes to the cascade-word step.
- R4: An address-1 write in the cascade-word step changes no output. It moves to the fourth-word step if `fourth_req` is 1, and otherwise to idle.
- R5: An address-1 write in the fourth-word step sets `fully_nested` from bit 4 and `auto_eoi` from bit 1, then returns to idle (`init_busy` 0).
- R6: An address-1 write loads the mask only while `init_busy` is 0. While it is 1, the mask is unchanged.
- R7: An address-0 write with bit 4 clear and bit 3 set is a mode command. Bit 2 set arms poll, and bit 2 clear leaves poll as it was. Bit 1 set copies bit 0 into `read_isr`. Bit 6 set copies bit 5 into `special_mask`. A cleared enable bit leaves its flag unchanged.
- R8: An address-0 write with bits 4 and 3 clear and bits 7:5 equal to 0 or 4 sets `rot_auto_eoi` to bit 7 and issues no strobe.
- R9: The other values of bits 7:5 each give exactly one strobe, for one cycle, in the cycle after the write: 1 gives `nseoi_stb`, 5 gives `rot_nseoi_stb`, 3 gives `seoi_stb`, 7 gives `rot_seoi_stb` and 6 gives `setprio_stb`. For 3, 7 and 6, `op_line` carries bits 2:0 of the write. Code 2 gives no strobe and no change.
- R10: A read with poll not armed returns, in the same cycle, the mask at address 1. At address 0 it returns `isr_in` when `read_isr` is 1, and `irr_in` otherwise.
- R11: A read with poll armed and no write in the same cycle disarms poll, whatever the address. If `poll_valid` is 1, it returns 0x80 OR `poll_line`, and in the next cycle it pulses `ack_stb` with `op_line` equal to that line. If `poll_valid` is 0, it returns 0 and issues no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 1 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| irr_in | input | 8 | Pending requests from the request latch |
| isr_in | input | 8 | In-service bits from the resolver |
| poll_valid | input | 1 | Resolver has a winning line |
| poll_line | input | 3 | Winning line number |
| vec_base | output | 8 | Vector base, bits 2:0 always 0 |
| single_mode | output | 1 | No cascade partner |
| fourth_req | output | 1 | Fourth initialization word expected |
| auto_eoi | output | 1 | Automatic end of interrupt |
| fully_nested | output | 1 | Special fully nested operation |
| rot_auto_eoi | output | 1 | Rotate priority on automatic end of interrupt |
| read_isr | output | 1 | Address-0 read returns in-service bits |
| special_mask | output | 1 | Special mask mode |
| poll_armed | output | 1 | Next read is a poll |
| mask | output | 8 | Interrupt mask |
| init_busy | output | 1 | Initialization sequence in progress |
| restart_stb | output | 1 | Clear controller state |
| nseoi_stb | output | 1 | Non-specific end of interrupt |
| rot_nseoi_stb | output | 1 | Rotating non-specific end of interrupt |
| seoi_stb | output | 1 | Specific end of interrupt |
| rot_seoi_stb | output | 1 | Rotate on specific end of interrupt |
| setprio_stb | output | 1 | Set lowest priority line |
| ack_stb | output | 1 | Acknowledge the polled line |
| op_line | output | 3 | Line operand for the line-carrying strobes |

## Verification
The bench runs all four shapes of the initialization sequence. A sequencer that ignored single mode or the fourth-word flag would take a later word as the wrong step: a mask would be swallowed, or `auto_eoi` would change when it should not. It writes address 1 during initialization, where a mask that loads would be corrupted, and it sends mode commands with their enable bits clear, where a flag that changes means the gating was dropped. Poll reads with and without a winner check the data byte, that the acknowledge comes one cycle later with the right line and never on an empty poll, and that poll is disarmed. Every command code, including the no-op code, is checked to give exactly its own strobe.

// File: rtl/irq_cmd_sequencer.sv
module irq_cmd_sequencer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic       addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] irr_in,
  input  logic [7:0] isr_in,
  input  logic       poll_valid,
  input  logic [2:0] poll_line,
  output logic [7:0] vec_base,
  output logic       single_mode,
  output logic       fourth_req,
  output logic       auto_eoi,
  output logic       fully_nested,
  output logic       rot_auto_eoi,
  output logic       read_isr,
  output logic       special_mask,
  output logic       poll_armed,
  output logic [7:0] mask,
  output logic       init_busy,
  output logic       restart_stb,
  output logic       nseoi_stb,
  output logic       rot_nseoi_stb,
  output logic       seoi_stb,
  output logic       rot_seoi_stb,
  output logic       setprio_stb,
  output logic       ack_stb,
  output logic [2:0] op_line
);

  typedef enum logic [1:0] {ST_IDLE, ST_BASE, ST_CASC, ST_FOURTH} step_t;
  step_t step;

  logic wr_ctl, wr_dat, is_init, is_mode, poll_take;
  assign wr_ctl    = wr_en & ~addr;
  assign wr_dat    = wr_en & addr;
  assign is_init   = wdata[4];
  assign is_mode   = ~wdata[4] & wdata[3];
  assign poll_take = rd_en & ~wr_en & poll_armed;
  assign init_busy = (step != ST_IDLE);

  always_comb begin
    if (poll_armed)
      rdata = poll_valid ? {5'b10000, poll_line} : 8'h00;
    else if (addr)
      rdata = mask;
    else
      rdata = read_isr ? isr_in : irr_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step          <= ST_IDLE;
      vec_base      <= '0;
      single_mode   <= 1'b0;
      fourth_req    <= 1'b0;
      auto_eoi      <= 1'b0;
      fully_nested  <= 1'b0;
      rot_auto_eoi  <= 1'b0;
      read_isr      <= 1'b0;
      special_mask  <= 1'b0;
      poll_armed    <= 1'b0;
      mask          <= '0;
      restart_stb   <= 1'b0;
      nseoi_stb     <= 1'b0;
      rot_nseoi_stb <= 1'b0;
      seoi_stb      <= 1'b0;
      rot_seoi_stb  <= 1'b0;
      setprio_stb   <= 1'b0;
      ack_stb       <= 1'b0;
      op_line       <= '0;
    end else begin
      restart_stb   <= 1'b0;
      nseoi_stb     <= 1'b0;
      rot_nseoi_stb <= 1'b0;
      seoi_stb      <= 1'b0;
      rot_seoi_stb  <= 1'b0;
      setprio_stb   <= 1'b0;
      ack_stb       <= 1'b0;

      if (poll_take) begin
        poll_armed <= 1'b0;
        if (poll_valid) begin
          ack_stb <= 1'b1;
          op_line <= poll_line;
        end
      end

      if (wr_ctl) begin
        if (is_init) begin
          restart_stb  <= 1'b1;
          step         <= ST_BASE;
          vec_base     <= '0;
          mask         <= '0;
          auto_eoi     <= 1'b0;
          fully_nested <= 1'b0;
          rot_auto_eoi <= 1'b0;
          read_isr     <= 1'b0;
          special_mask <= 1'b0;
          poll_armed   <= 1'b0;
          single_mode  <= wdata[1];
          fourth_req   <= wdata[0];
        end else if (is_mode) begin
          if (wdata[2]) poll_armed   <= 1'b1;
          if (wdata[1]) read_isr     <= wdata[0];
          if (wdata[6]) special_mask <= wdata[5];
        end else begin
          case (wdata[7:5])
            3'd0, 3'd4: rot_auto_eoi <= wdata[7];
            3'd1: nseoi_stb <= 1'b1;
            3'd5: rot_nseoi_stb <= 1'b1;
            3'd3: begin seoi_stb     <= 1'b1; op_line <= wdata[2:0]; end
            3'd6: begin setprio_stb  <= 1'b1; op_line <= wdata[2:0]; end
            3'd7: begin rot_seoi_stb <= 1'b1; op_line <= wdata[2:0]; end
            default: ;
          endcase
        end
      end else if (wr_dat) begin
        case (step)
          ST_IDLE: mask <= wdata;
          ST_BASE: begin
            vec_base <= {wdata[7:3], 3'b000};
            if (single_mode) step <= fourth_req ? ST_FOURTH : ST_IDLE;
            else             step <= ST_CASC;
          end
          ST_CASC: step <= fourth_req ? ST_FOURTH : ST_IDLE;
          ST_FOURTH: begin
            fully_nested <= wdata[4];
            auto_eoi     <= wdata[1];
            step         <= ST_IDLE;
          end
          default: step <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

module irq_cmd_sequencer_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_en,
  input logic       addr,
  input logic [7:0] wdata,
  input logic       poll_valid,
  input logic [2:0] poll_line,
  input logic       poll_armed,
  input logic [7:0] mask,
  input logic       init_busy,
  input logic       restart_stb,
  input logic       nseoi_stb,
  input logic       rot_nseoi_stb,
  input logic       seoi_stb,
  input logic       rot_seoi_stb,
  input logic       setprio_stb,
  input logic       ack_stb,
  input logic [2:0] op_line
);

  assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wdata[4]) |=> (restart_stb && mask == 8'h00 && init_busy && !poll_armed));

  assert_mask_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr && !init_busy) |=> (mask == $past(wdata)));

  assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr && init_busy) |=> $stable(mask));

  assert_single_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({restart_stb, nseoi_stb, rot_nseoi_stb, seoi_stb, rot_seoi_stb, setprio_stb, ack_stb}));

  assert_specific_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wdata[7:3] == 5'b01100) |=> (seoi_stb && op_line == $past(wdata[2:0])));

  assert_poll_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && poll_armed && poll_valid) |=> (ack_stb && op_line == $past(poll_line) && !poll_armed));

  assert_poll_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && poll_armed && !poll_valid) |=> (!ack_stb && !poll_armed));

endmodule

bind irq_cmd_sequencer irq_cmd_sequencer_sva u_sva (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .poll_valid(poll_valid), .poll_line(poll_line),
  .poll_armed(poll_armed), .mask(mask), .init_busy(init_busy),
  .restart_stb(restart_stb), .nseoi_stb(nseoi_stb), .rot_nseoi_stb(rot_nseoi_stb),
  .seoi_stb(seoi_stb), .rot_seoi_stb(rot_seoi_stb), .setprio_stb(setprio_stb),
  .ack_stb(ack_stb), .op_line(op_line)
);

// File: tb/irq_cmd_sequencer_tb.sv
`timescale 1ns/1ps
module irq_cmd_sequencer_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, wr_en, rd_en, addr, poll_valid;
  logic [7:0] wdata, rdata, irr_in, isr_in, vec_base, mask;
  logic [2:0] poll_line, op_line;
  logic single_mode, fourth_req, auto_eoi, fully_nested, rot_auto_eoi;
  logic read_isr, special_mask, poll_armed, init_busy;
  logic restart_stb, nseoi_stb, rot_nseoi_stb, seoi_stb, rot_seoi_stb, setprio_stb, ack_stb;

  irq_cmd_sequencer u_dut (.*);

  int checks = 0, fails = 0;

  logic [7:0] m_base, m_mask;
  logic m_single, m_four, m_aeoi, m_fnm, m_rot, m_rsel, m_smm, m_poll;
  int m_step;
  logic [6:0] e_stb;
  logic [2:0] e_line;
  logic e_line_vld;

  function automatic logic [63:0] dut_cfg();
    return {vec_base, single_mode, fourth_req, auto_eoi, fully_nested, rot_auto_eoi,
            read_isr, special_mask, poll_armed, mask, init_busy};
  endfunction

  function automatic logic [63:0] mdl_cfg();
    return {m_base, m_single, m_four, m_aeoi, m_fnm, m_rot,
            m_rsel, m_smm, m_poll, m_mask, logic'(m_step != 0)};
  endfunction

  function automatic logic [6:0] dut_stb();
    return {restart_stb, nseoi_stb, rot_nseoi_stb, seoi_stb, rot_seoi_stb, setprio_stb, ack_stb};
  endfunction

  function automatic logic [7:0] exp_read(input logic a, input logic pv, input logic [2:0] pl,
                                          input logic [7:0] irr, input logic [7:0] isr);
    if (m_poll) return pv ? (8'h80 | {5'b0, pl}) : 8'h00;
    if (a) return m_mask;
    return m_rsel ? isr : irr;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_after(input string req);
    chk(req, dut_cfg(), mdl_cfg());
    chk(req, {57'b0, dut_stb()}, {57'b0, e_stb});
    if (e_line_vld) chk(req, {61'b0, op_line}, {61'b0, e_line});
  endtask

  task automatic mdl_clear();
    m_base = 0; m_mask = 0; m_single = 0; m_four = 0; m_aeoi = 0; m_fnm = 0;
    m_rot = 0; m_rsel = 0; m_smm = 0; m_poll = 0; m_step = 0;
  endtask

  task automatic do_write(input logic a, input logic [7:0] d);
    string tag;
    e_stb = 0; e_line_vld = 0; e_line = d[2:0];
    if (!a) begin
      if (d[4]) begin
        mdl_clear(); m_single = d[1]; m_four = d[0]; m_step = 1; e_stb = 7'b1000000; tag = "R2";
      end else if (d[3]) begin
        if (d[2]) m_poll = 1;
        if (d[1]) m_rsel = d[0];
        if (d[6]) m_smm = d[5];
        tag = "R7";
      end else begin
        tag = "R9";
        case (d[7:5])
          3'd0, 3'd4: begin m_rot = d[7]; tag = "R8"; end
          3'd1: e_stb = 7'b0100000;
          3'd5: e_stb = 7'b0010000;
          3'd3: begin e_stb = 7'b0001000; e_line_vld = 1; end
          3'd7: begin e_stb = 7'b0000100; e_line_vld = 1; end
          3'd6: begin e_stb = 7'b0000010; e_line_vld = 1; end
          default: ;
        endcase
      end
    end else begin
      case (m_step)
        0: begin m_mask = d; tag = "R6"; end
        1: begin m_base = d & 8'hF8; m_step = m_single ? (m_four ? 3 : 0) : 2; tag = "R3"; end
        2: begin m_step = m_four ? 3 : 0; tag = "R4"; end
        default: begin m_fnm = d[4]; m_aeoi = d[1]; m_step = 0; tag = "R5"; end
      endcase
    end
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
    check_after(tag);
  endtask

  task automatic do_read(input logic a, input logic pv, input logic [2:0] pl,
                         input logic [7:0] irr, input logic [7:0] isr);
    string tag;
    logic [7:0] er;
    tag = m_poll ? "R11" : "R10";
    er = exp_read(a, pv, pl, irr, isr);
    e_stb = 0; e_line_vld = 0; e_line = pl;
    @(negedge clk); rd_en = 1; addr = a; poll_valid = pv; poll_line = pl; irr_in = irr; isr_in = isr;
    #1 chk(tag, {56'b0, rdata}, {56'b0, er});
    if (m_poll) begin
      m_poll = 0;
      if (pv) begin e_stb = 7'b0000001; e_line_vld = 1; end
    end
    @(negedge clk); rd_en = 0;
    check_after(tag);
  endtask

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1259));
    rst_n = 0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
    irr_in = 0; isr_in = 0; poll_valid = 0; poll_line = 0;
    mdl_clear(); e_stb = 0; e_line_vld = 0; e_line = 0;
    repeat (3) @(negedge clk);
    check_after("R1");
    rst_n = 1;
    @(negedge clk);
    check_after("R1");

    do_write(0, 8'h11); do_write(1, 8'h2F); do_write(1, 8'h04); do_write(1, 8'h13);
    do_write(1, 8'hA5); do_read(1, 0, 0, 8'h0F, 8'hF0);
    do_read(0, 0, 0, 8'h3C, 8'hC3);
    do_write(0, 8'h0B); do_read(0, 0, 0, 8'h3C, 8'hC3);
    do_write(0, 8'h08); do_write(0, 8'h68); do_write(0, 8'h28);
    do_write(0, 8'h48);
    do_write(0, 8'h20); do_write(0, 8'hA0); do_write(0, 8'h63); do_write(0, 8'hC5);
    do_write(0, 8'hE2); do_write(0, 8'h40); do_write(0, 8'h87); do_write(0, 8'h00);
    do_write(0, 8'h0C); do_read(1, 1, 3'd5, 8'h20, 8'h00);
    do_read(0, 0, 0, 8'h20, 8'h01);
    do_write(0, 8'h0C); do_read(0, 0, 3'd2, 8'h00, 8'h00);
    do_write(0, 8'h12); do_write(1, 8'hFF); do_write(1, 8'h5A);
    do_write(0, 8'h13); do_write(1, 8'h41); do_write(1, 8'h12);
    do_write(0, 8'h10); do_write(1, 8'h77); do_write(1, 8'h99); do_write(1, 8'h3C);
    do_write(0, 8'h11); do_write(1, 8'h80); do_write(1, 8'hEE); do_write(1, 8'h02);

    for (int i = 0; i < 600; i++) begin
      int r;
      logic [7:0] d;
      r = $urandom % 10;
      d = 8'($urandom);
      if (r < 6) begin
        logic a;
        a = 1'($urandom);
        if (!a && d[4] && ($urandom % 5 != 0)) d[4] = 1'b0;
        do_write(a, d);
      end else begin
        do_read(1'($urandom), 1'($urandom), 3'($urandom), 8'($urandom), 8'($urandom));
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule